// File: doc/BRIEF.md
# Pixel Format Packer, 32-bit RGBA to 16-bit RGBA with 1-bit Alpha

This block takes a stream of 32-bit pixels carrying four 8-bit channels and emits one 16-bit pixel for each. The three colour channels shrink to 5 bits each. The reduction is a true rescale of the 0..255 range onto 0..31, truncated toward zero, and not a drop of the low bits. The alpha channel becomes a single bit that is set whenever the source alpha is anything other than zero.

Both sides use a valid/ready handshake. The result sits in a single output register, so a pixel accepted on one clock edge appears at the output just after that edge. The upstream side is stalled only while that register holds a pixel that the downstream side is refusing.

The input word carries red in bits 7:0, green in bits 15:8, blue in bits 23:16 and alpha in bits 31:24. The output word carries red in bits 15:11, green in bits 10:6, blue in bits 5:1 and alpha in bit 0.

Top module: `px_pack5551`

## Requirements
- R1: The output red field, bits 15:11, equals floor(r*31/255), where r is input bits 7:0.
- R2: The output green field, bits 10:6, equals floor(g*31/255), where g is input bits 15:8.
- R3: The output blue field, bits 5:1, equals floor(b*31/255), where b is input bits 23:16.
- R4: Output bit 0 is 1 when input bits 31:24 are nonzero and 0 when they are zero.
- R5: A colour field reads 31 only for a channel value of 255. A value of 254 gives 30.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R7: in_ready is high exactly when out_ready is high or out_valid is low.
- R8: While rst_n is low, and on the first edge after its release, out_valid is low.
- R9: A pixel accepted on an edge (in_valid and in_ready both high) is presented with out_valid high after that edge. Pixels leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source pixel is present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_data | input | 32 | Source pixel: alpha, blue, green, red from most to least significant byte |
| out_valid | output | 1 | Packed pixel is present |
| out_ready | input | 1 | Sink takes the packed pixel this cycle |
| out_data | output | 16 | Packed pixel: red 15:11, green 10:6, blue 5:1, alpha 0 |

## Verification
The hardest case to reach from the ports is a new pixel arriving while the output register is full and the sink is stalled. Here the register must hold its old value, in_ready must drop, and the new pixel must be taken on the very edge at which the old one leaves. A directed sequence holds out_ready low across two offered pixels and then releases it. All 256 values of every channel are then streamed twice: once at full rate, and once with random gaps on both valid and ready. The random pass makes simultaneous accept-and-drain edges frequent, and each result is checked field by field against an integer reference kept in order.

// File: rtl/px_pack5551.sv
module px_pack5551 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_data
);

  function automatic logic [4:0] scale5(input logic [7:0] c);
    logic [12:0] p;
    logic [12:0] s;
    p = {c, 5'b0} - {5'b0, c};
    s = p + 13'd1 + {8'b0, p[12:8]};
    return 5'(s >> 8);
  endfunction

  logic [15:0] packed_w;
  logic        take;

  assign packed_w = {scale5(in_data[7:0]),
                     scale5(in_data[15:8]),
                     scale5(in_data[23:16]),
                     |in_data[31:24]};

  assign in_ready = out_ready | ~out_valid;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= packed_w;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

module px_pack5551_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data
);

  // R8
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  free_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready || !out_valid) |-> in_ready);

  // R9
  accept_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R4
  alpha_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data[0] == ($past(in_data[31:24]) != 8'd0)));

  // R5
  red_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((out_data[15:11] == 5'd31) == ($past(in_data[7:0]) == 8'hFF)));

endmodule

bind px_pack5551 px_pack5551_chk chk_i (.*);

// File: tb/px_pack5551_tb.sv
module px_pack5551_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] pix [256];
  logic [15:0] exp_q [$];

  always #5 clk = ~clk;

  px_pack5551 dut_i (.*);

  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    {32'hFFFFFFFF, 16'hFFFF},
    {32'h00000000, 16'h0000},
    {32'h01FEFF09, 16'h0FFD},
    {32'h80080020, 16'h1801},
    {32'h00218000, 16'h03C8},
    {32'h01000000, 16'h0001}
  };

  function automatic logic [15:0] ref_pack(input logic [31:0] d);
    int r, g, b;
    r = int'(d[7:0]) * 31 / 255;
    g = int'(d[15:8]) * 31 / 255;
    b = int'(d[23:16]) * 31 / 255;
    return {5'(r), 5'(g), 5'(b), d[31:24] != 8'd0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_pix(input logic [15:0] act, input logic [15:0] exp);
    chk("R1 red",   32'(act[15:11]), 32'(exp[15:11]));
    chk("R2 green", 32'(act[10:6]),  32'(exp[10:6]));
    chk("R3 blue",  32'(act[5:1]),   32'(exp[5:1]));
    chk("R4 alpha", 32'(act[0]),     32'(exp[0]));
  endtask

  task automatic send_one(input logic [31:0] d, input logic [15:0] exp, input string tag);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1;
    in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 valid", 32'(out_valid), 32'd1);
    chk(tag, 32'(out_data), 32'(exp));
  endtask

  task automatic run_stream(input bit bp);
    int sent = 0;
    int got = 0;
    while (got < 256) begin
      @(negedge clk);
      out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
      if (sent < 256) begin
        in_valid = bp ? ($urandom % 4 != 0) : 1'b1;
        in_data = pix[sent];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (out_valid && out_ready) begin
        chk_pix(out_data, exp_q.pop_front());
        got++;
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_pack(pix[sent]));
        sent++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++)
      pix[i] = {8'(i), 8'(255 - i), 8'(i) ^ 8'h5A, 8'(i)};

    repeat (3) @(negedge clk);
    chk("R8 valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 valid after release", 32'(out_valid), 32'd0);
    chk("R7 ready when empty", 32'(in_ready), 32'd1);

    for (int v = 0; v < NV; v++)
      send_one(VEC[v][47:16], VEC[v][15:0], "R5 table vector");

    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_data = 32'h01FF0012;
    @(negedge clk);
    in_data = 32'h00FE7F80;
    #1;
    chk("R7 blocked while stalled", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R6 held valid", 32'(out_valid), 32'd1);
    chk("R6 held data", 32'(out_data), 32'(ref_pack(32'h01FF0012)));
    out_ready = 1'b1;
    #1;
    chk("R7 ready on drain", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next in order", 32'(out_data), 32'(ref_pack(32'h00FE7F80)));
    chk("R5 254 gives 30", 32'(out_data[5:1]), 32'd30);
    @(negedge clk);
    chk("R9 drained", 32'(out_valid), 32'd0);

    run_stream(1'b0);
    run_stream(1'b1);
    chk("R9 all returned", 32'(exp_q.size()), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule